// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shift Register

This block is an eight-stage register that converts a parallel byte into a serial bit stream. It lives inside a faster system clock domain and treats its two shift-clock pins as slow external levels. Each pin is resynchronised and edge-detected. A shift happens once for every rising edge of the OR of the two pins. The two pins are fully interchangeable: either one can act as the clock while the other acts as a gate that blocks it when held high.

A mode pin selects what the register does. When the pin is low, every stage keeps copying its own parallel input, and this overrides any shift. When the pin is high, parallel inputs are ignored and each shift pulse moves data one stage toward the last stage. A fill bit enters the first stage on each shift. The last stage drives a true serial output and a complemented serial output. An observation bus shows all stages at once.

The data path is level-based and has no valid/ready handshake. The block never pushes back on its source. The source controls the pace of the stream through the clock pins, and each rising edge of the pin OR moves the stream by exactly one bit.

Top module: `gcsr_top`

## Requirements
- R1: A synchronous active-high `rst` clears all stages to 0, so `tail_q` is 0 and `tail_qn` is 1.
- R2: While `mode_shift` is 0, each stage `stages_o[i]` follows `par_in[i]`. This continues while `par_in` changes.
- R3: While `mode_shift` is 1, changes on `par_in` leave every stage unchanged.
- R4: With `mode_shift` 1 and `pin_clk_b` low, a rising edge on `pin_clk_a` performs one shift. `fill_bit` enters stage 0, and stage i takes the old value of stage i-1.
- R5: With `pin_clk_a` low, a rising edge on `pin_clk_b` performs the same single shift as in R4.
- R6: While either clock pin is held high, edges on the other pin cause no shift. The falling edge of the OR of the pins also causes no shift.
- R7: `tail_q` equals the last stage, `stages_o[7]`, and `tail_qn` is its complement at all times.
- R8: A load overrides a shift detected in the same system cycle. After a pin edge that arrives while loading, the stages hold exactly `par_in`, with no shift applied later.
- R9: After a load and 8 shifts, `tail_q` presents `par_in[7]` first and `par_in[0]` last. After that, every stage holds the fill bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_shift | input | 1 | 0: load from par_in, 1: shift on pin edges |
| pin_clk_a | input | 1 | Asynchronous shift clock pin (interchangeable with pin_clk_b) |
| pin_clk_b | input | 1 | Asynchronous shift clock / gate pin |
| fill_bit | input | 1 | Serial bit shifted into stage 0 |
| par_in | input | 8 | Parallel word; bit i loads stage i |
| tail_q | output | 1 | Last stage (serial output) |
| tail_qn | output | 1 | Complement of tail_q |
| stages_o | output | 8 | All stages, bit i is stage i |

## Verification
The assertions assume that the pins change slowly compared with the system clock. Each pin must hold its level long enough to pass the two-flop synchroniser, so that every real edge becomes exactly one detected edge. They also assume that `fill_bit` and `par_in` are steady when a shift or load is sampled. The stimulus meets these conditions by changing inputs only on falling system-clock edges and then holding them for several system cycles. It also keeps both clock pins low during reset, so no spurious edge appears when reset is released.

// File: rtl/gcsr_pkg.sv
package gcsr_pkg;
  localparam int unsigned STAGES_DEF = 8;
  localparam int unsigned SYNC_DEF   = 2;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } stage_op_e;
endpackage

// File: rtl/gcsr_sync.sv
module gcsr_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] chain;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ff
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[DEPTH-1];
endmodule

// File: rtl/gcsr_edge.sv
module gcsr_edge (
  input  logic clk,
  input  logic rst,
  input  logic a_s,
  input  logic b_s,
  output logic pulse
);
  logic or_now;
  logic or_prev;

  assign or_now = a_s | b_s;

  always_ff @(posedge clk) begin
    if (rst) or_prev <= 1'b0;
    else     or_prev <= or_now;
  end

  assign pulse = or_now & ~or_prev;

  // R6: a held-high OR never yields back-to-back pulses
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/gcsr_stages.sv
module gcsr_stages
  import gcsr_pkg::*;
#(
  parameter int unsigned STAGES = STAGES_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_mode,
  input  logic              pulse,
  input  logic              fill,
  input  logic [STAGES-1:0] par,
  output logic [STAGES-1:0] stage
);
  stage_op_e op;

  always_comb begin
    if (!shift_mode)  op = OP_LOAD;   // load wins over a same-cycle pulse
    else if (pulse)   op = OP_SHIFT;
    else              op = OP_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
    end else begin
      case (op)
        OP_LOAD:  stage <= par;
        OP_SHIFT: stage <= {stage[STAGES-2:0], fill};
        default:  stage <= stage;
      endcase
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (stage == '0));

  p_load_follows_r2: assert property (@(posedge clk) disable iff (rst)
    !shift_mode |=> (stage == $past(par)));

  p_shift_step_r4: assert property (@(posedge clk) disable iff (rst)
    (shift_mode && pulse) |=> (stage == {$past(stage[STAGES-2:0]), $past(fill)}));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (shift_mode && !pulse) |=> $stable(stage));
endmodule

// File: rtl/gcsr_top.sv
module gcsr_top
  import gcsr_pkg::*;
#(
  parameter int unsigned STAGES     = STAGES_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_shift,
  input  logic              pin_clk_a,
  input  logic              pin_clk_b,
  input  logic              fill_bit,
  input  logic [STAGES-1:0] par_in,
  output logic              tail_q,
  output logic              tail_qn,
  output logic [STAGES-1:0] stages_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic a_s, b_s, mode_s, pulse;

  gcsr_sync #(.DEPTH(SYNC_DEPTH)) u_sync_a (
    .clk(clk), .rst(rst), .d(pin_clk_a), .q(a_s));
  gcsr_sync #(.DEPTH(SYNC_DEPTH)) u_sync_b (
    .clk(clk), .rst(rst), .d(pin_clk_b), .q(b_s));
  gcsr_sync #(.DEPTH(SYNC_DEPTH)) u_sync_m (
    .clk(clk), .rst(rst), .d(mode_shift), .q(mode_s));

  gcsr_edge u_edge (
    .clk(clk), .rst(rst), .a_s(a_s), .b_s(b_s), .pulse(pulse));

  gcsr_stages #(.STAGES(STAGES)) u_stages (
    .clk(clk), .rst(rst), .shift_mode(mode_s), .pulse(pulse),
    .fill(fill_bit), .par(par_in), .stage(stages_o));

  assign tail_q  = stages_o[LAST];
  assign tail_qn = ~stages_o[LAST];

  // R7: serial output tracks the observed last stage
  p_tail_matches_r7: assert property (@(posedge clk) disable iff (rst)
    (tail_q == stages_o[LAST]) && (tail_qn != tail_q));
endmodule

// File: tb/gcsr_top_tb_top.sv
module gcsr_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_shift = 1'b0;
  logic       pin_clk_a = 1'b0;
  logic       pin_clk_b = 1'b0;
  logic       fill_bit = 1'b0;
  logic [7:0] par_in = 8'h00;
  logic       tail_q, tail_qn;
  logic [7:0] stages_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  gcsr_top dut_i (
    .clk(clk), .rst(rst), .mode_shift(mode_shift),
    .pin_clk_a(pin_clk_a), .pin_clk_b(pin_clk_b),
    .fill_bit(fill_bit), .par_in(par_in),
    .tail_q(tail_q), .tail_qn(tail_qn), .stages_o(stages_o));

  // {word[7:0], fill, use_pin_b}
  localparam logic [9:0] VEC [4] = '{10'h296, 10'h0F1, 10'h203, 10'h004};

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse_pin(input bit use_b);
    if (use_b) pin_clk_b = 1'b1; else pin_clk_a = 1'b1;
    settle();
    if (use_b) pin_clk_b = 1'b0; else pin_clk_a = 1'b0;
    settle();
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 stages", stages_o, 8'h00);
    chk("R1 tail_qn", {7'd0, tail_qn}, 8'h01);
    rst = 1'b0;
    settle();

    // Vector table: load, 8 shifts (R4 on pin A, R5 on pin B), R9 order
    for (int v = 0; v < 4; v++) begin
      mode_shift = 1'b0;
      par_in = VEC[v][9:2];
      settle();
      chk("R2 load", stages_o, VEC[v][9:2]);
      mode_shift = 1'b1;
      fill_bit = VEC[v][1];
      settle();
      for (int i = 0; i < 8; i++) begin
        chk(VEC[v][0] ? "R9/R5 tail" : "R9/R4 tail", {7'd0, tail_q}, {7'd0, VEC[v][9-i]});
        chk("R7 tail_qn", {7'd0, tail_qn}, {7'd0, ~VEC[v][9-i]});
        pulse_pin(VEC[v][0]);
      end
      chk("R9 fill", stages_o, {8{VEC[v][1]}});
    end

    // R2: stages follow par_in changes while loading
    mode_shift = 1'b0;
    par_in = 8'h12; settle();
    par_in = 8'h5A; settle();
    chk("R2 follow", stages_o, 8'h5A);

    // R8: pin edge during load does not shift, even after leaving load
    fill_bit = 1'b1;
    pulse_pin(1'b0);
    chk("R8 load over edge", stages_o, 8'h5A);
    mode_shift = 1'b1; settle();
    chk("R8 no late shift", stages_o, 8'h5A);

    // R3: par_in ignored while shifting
    par_in = 8'hFF; settle();
    chk("R3 par ignored", stages_o, 8'h5A);

    // R8: load and pin rise in same cycle -> load wins
    par_in = 8'hC3;
    mode_shift = 1'b0; pin_clk_a = 1'b1;
    settle();
    chk("R8 same cycle", stages_o, 8'hC3);
    mode_shift = 1'b1; settle();
    chk("R8 same cycle after", stages_o, 8'hC3);
    pin_clk_a = 1'b0; settle();
    chk("R6 fall no shift", stages_o, 8'hC3);

    // R6: pin A held high gates pin B
    exp = 8'hC3;
    fill_bit = 1'b0;
    pin_clk_a = 1'b1; settle();
    exp = {exp[6:0], 1'b0};
    chk("R4 rise", stages_o, exp);
    for (int k = 0; k < 3; k++) pulse_pin(1'b1);
    chk("R6 gated by A", stages_o, exp);
    pin_clk_a = 1'b0; settle();
    chk("R6 fall of OR", stages_o, exp);

    // R6: pin B held high gates pin A
    fill_bit = 1'b1;
    pin_clk_b = 1'b1; settle();
    exp = {exp[6:0], 1'b1};
    chk("R5 rise", stages_o, exp);
    for (int k = 0; k < 3; k++) pulse_pin(1'b0);
    chk("R6 gated by B", stages_o, exp);
    pin_clk_b = 1'b0; settle();
    chk("R7 tail", {7'd0, tail_q}, {7'd0, exp[7]});

    // R1: reset mid-stream clears
    rst = 1'b1; settle();
    chk("R1 reclear", stages_o, 8'h00);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule